// File: doc/BRIEF.md
# Masked Configuration Header Register File

This block holds the 256-byte type-0 configuration header of a single bus function. A host reaches it with one access per cycle: an 8-bit byte offset, an access length of one, two or four bytes, 32 bits of write data and a write strobe. Read data is returned combinationally from the current contents. Every written byte passes through a per-byte write mask, so identity fields, type bits and unimplemented windows keep their reset contents whatever is written.

The mask and the reset image are fixed when the block is elaborated. They come from the identity parameters and from a table of base-address region sizes, with the expansion-ROM window as the last entry. A region whose size is not a power of two is treated as absent. When a write actually alters one of the six base-address registers, or flips the I/O or memory decode enable, the block raises a one-cycle remap pulse. Downstream address decoders use that pulse to reload their windows.

Top module: `masked_cfg_space`

## Requirements
- R1: After reset, bytes 0x00-0x01 hold the vendor ID and bytes 0x02-0x03 the device ID, both little-endian. Byte 0x08 holds the revision, bytes 0x09-0x0B the class code, and byte 0x0E the header type. Each implemented I/O base register holds 1 in its low byte. Every other byte is zero, including the command register at 0x04.
- R2: The identity bytes, the status bytes 0x06-0x07 and the header-type byte ignore writes.
- R3: Byte 0x0C, byte 0x3C and every byte from 0x40 to 0xFF take any written value in full.
- R4: At byte 0x04, only bit 0 (I/O decode), bit 1 (memory decode) and bit 2 (bus master) are writable. Byte 0x05 ignores writes.
- R5: Base register n sits at 0x10+4n for n in 0..5, and the ROM register sits at 0x30. For a region of power-of-two size S, the writable bits of the 32-bit register are ~(S-1). The ROM register also has bit 0, its enable, writable.
- R6: A region configured with size zero or a size that is not a power of two reads as zero and ignores writes.
- R7: A multi-byte write places byte k of the write data at offset+k, least significant byte first. Bytes that fall beyond 0xFF are dropped and do not wrap to 0x00.
- R8: A byte read returns the byte zero-extended. A word read returns all ones above offset 0xFE, and a dword read returns all ones above offset 0xFC. A length code other than 1, 2 or 4 reads as all ones and writes nothing.
- R9: The remap output pulses high for exactly the one cycle after a clock edge at which a write changed any byte in 0x10-0x27, or changed bit 0 or bit 1 of byte 0x04.
- R10: A write that leaves those bits unchanged, including writes that touch only the ROM register or the bus-master bit, produces no remap pulse.
- R11: A write is visible to reads from the cycle after its clock edge. Without a write strobe the contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte offset of the access |
| len_i | input | 3 | Access length in bytes: 1, 2 or 4 |
| wr_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data, lane k goes to offset+k |
| rdata_o | output | 32 | Combinational read data |
| remap_o | output | 1 | One-cycle pulse after a decode-relevant change |

## Verification
The properties assume that the inputs are stable around the rising edge. They also assume that a write is a single-cycle strobe whose result is judged in the following cycle. Identity and reserved bits are checked on the register image itself, so they hold for any stimulus. The stimulus changes inputs only on falling edges and keeps each operation to one cycle. It covers length codes inside and outside the legal set, including offsets near the top of the space, so that the range rules and the drop-at-end rule are reached without relying on wrap-around behaviour the block does not define.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int CFG_BYTES    = 256;
  localparam int NUM_BARS     = 6;
  localparam int BAR_BASE_OFF = 'h10;
  localparam int BAR_WIN_LO   = BAR_BASE_OFF;
  localparam int BAR_WIN_HI   = BAR_BASE_OFF + 4 * NUM_BARS - 1;
  localparam int ROM_OFF      = 'h30;
  localparam int CMD_OFF      = 'h04;
  localparam int CLS_OFF      = 'h0C;
  localparam int IRQ_LINE_OFF = 'h3C;
  localparam int DEV_SPEC_OFF = 'h40;
  localparam logic [7:0] CMD_WMASK = 8'h07;

  typedef logic [NUM_BARS:0][31:0] bar_vec_t;
  typedef logic [CFG_BYTES-1:0][7:0] cfg_img_t;

  function automatic logic is_pow2(logic [31:0] v);
    return (v != '0) && ((v & (v - 32'd1)) == '0);
  endfunction

  function automatic int bar_off(int b);
    return (b == NUM_BARS) ? ROM_OFF : BAR_BASE_OFF + 4 * b;
  endfunction

  function automatic logic [2:0] len_bytes(logic [2:0] len);
    case (len)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd4:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic cfg_img_t build_mask(bar_vec_t sz);
    cfg_img_t    m;
    logic [31:0] w;
    m = '0;
    m[CMD_OFF]      = CMD_WMASK;
    m[CLS_OFF]      = 8'hFF;
    m[IRQ_LINE_OFF] = 8'hFF;
    for (int i = DEV_SPEC_OFF; i < CFG_BYTES; i++) m[i] = 8'hFF;
    for (int b = 0; b <= NUM_BARS; b++) begin
      w = is_pow2(sz[b]) ? ~(sz[b] - 32'd1) : '0;
      if (b == NUM_BARS && is_pow2(sz[b])) w[0] = 1'b1;
      for (int k = 0; k < 4; k++) m[bar_off(b) + k] = w[8*k +: 8];
    end
    return m;
  endfunction

  function automatic cfg_img_t build_init(logic [15:0] vid, logic [15:0] did,
                                          logic [7:0] rev, logic [23:0] cls,
                                          logic [7:0] hdr, bar_vec_t sz,
                                          logic [NUM_BARS-1:0] io);
    cfg_img_t v;
    v = '0;
    v[0]    = vid[7:0];
    v[1]    = vid[15:8];
    v[2]    = did[7:0];
    v[3]    = did[15:8];
    v[8]    = rev;
    v[9]    = cls[7:0];
    v['hA]  = cls[15:8];
    v['hB]  = cls[23:16];
    v['hE]  = hdr;
    for (int b = 0; b < NUM_BARS; b++)
      if (is_pow2(sz[b]) && io[b]) v[bar_off(b)] = 8'h01;
    return v;
  endfunction
endpackage

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_space_pkg::*;
#(
  parameter cfg_img_t WMASK = '0,
  parameter cfg_img_t INIT  = '0,
  parameter int       LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           addr_i,
  input  logic [2:0]           len_i,
  input  logic                 wr_i,
  input  logic [8*LANES-1:0]   wdata_i,
  output cfg_img_t             cfg_q_o,
  output cfg_img_t             cfg_d_o
);
  localparam int IDXW = $clog2(CFG_BYTES) + 1;

  logic [2:0]             nbytes;
  logic [LANES-1:0]       lane_en;
  logic [LANES-1:0][7:0]  lane_idx;
  cfg_img_t               cfg_q, cfg_d;

  assign nbytes = len_bytes(len_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDXW-1:0] idx;
    assign idx         = {1'b0, addr_i} + IDXW'(k);
    // lanes past the last byte are dropped, never wrapped
    assign lane_en[k]  = wr_i && (3'(k) < nbytes) && !idx[IDXW-1];
    assign lane_idx[k] = idx[7:0];
  end

  always_comb begin
    cfg_d = cfg_q;
    for (int k = 0; k < LANES; k++) begin
      if (lane_en[k])
        cfg_d[lane_idx[k]] = (cfg_q[lane_idx[k]] & ~WMASK[lane_idx[k]])
                           | (wdata_i[8*k +: 8] & WMASK[lane_idx[k]]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= INIT;
    else         cfg_q <= cfg_d;
  end

  assign cfg_q_o = cfg_q;
  assign cfg_d_o = cfg_d;
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
  import cfg_space_pkg::*;
(
  input  cfg_img_t    cfg_i,
  input  logic [7:0]  addr_i,
  input  logic [2:0]  len_i,
  output logic [31:0] rdata_o
);
  logic [7:0] a1, a2, a3;
  assign a1 = addr_i + 8'd1;
  assign a2 = addr_i + 8'd2;
  assign a3 = addr_i + 8'd3;

  always_comb begin
    rdata_o = '1;
    case (len_i)
      3'd1: rdata_o = {24'h0, cfg_i[addr_i]};
      3'd2: if (addr_i <= 8'hFE) rdata_o = {16'h0, cfg_i[a1], cfg_i[addr_i]};
      3'd4: if (addr_i <= 8'hFC) rdata_o = {cfg_i[a3], cfg_i[a2], cfg_i[a1], cfg_i[addr_i]};
      default: rdata_o = '1;
    endcase
  end
endmodule

// File: rtl/cfg_remap_det.sv
module cfg_remap_det
  import cfg_space_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cfg_img_t cfg_q_i,
  input  cfg_img_t cfg_d_i,
  output logic     remap_o
);
  localparam int WIN = BAR_WIN_HI - BAR_WIN_LO + 1;

  logic [WIN-1:0] bar_diff;
  logic           cmd_diff, remap_q;

  for (genvar i = 0; i < WIN; i++) begin : g_win
    assign bar_diff[i] = cfg_q_i[BAR_WIN_LO + i] != cfg_d_i[BAR_WIN_LO + i];
  end

  assign cmd_diff = (cfg_q_i[CMD_OFF][1:0] ^ cfg_d_i[CMD_OFF][1:0]) != 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) remap_q <= 1'b0;
    else         remap_q <= (|bar_diff) || cmd_diff;
  end

  assign remap_o = remap_q;
endmodule

// File: rtl/masked_cfg_space.sv
module masked_cfg_space
  import cfg_space_pkg::*;
#(
  parameter logic [15:0]         VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0]         DEVICE_ID   = 16'h0042,
  parameter logic [7:0]          REVISION    = 8'h03,
  parameter logic [23:0]         CLASS_CODE  = 24'h020000,
  parameter logic [7:0]          HEADER_TYPE = 8'h00,
  // entry NUM_BARS is the expansion ROM window
  parameter bar_vec_t            BAR_SIZE    = {32'h0001_0000, 32'h0, 32'h0, 32'h0,
                                                32'h0000_0300, 32'h0000_0020, 32'h0000_1000},
  parameter logic [NUM_BARS-1:0] BAR_IO      = 6'b000010
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic [2:0]  len_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        remap_o
);
  localparam cfg_img_t WMASK = build_mask(BAR_SIZE);
  localparam cfg_img_t INIT  = build_init(VENDOR_ID, DEVICE_ID, REVISION, CLASS_CODE,
                                          HEADER_TYPE, BAR_SIZE, BAR_IO);

  cfg_img_t cfg_q, cfg_d;

  cfg_store #(.WMASK(WMASK), .INIT(INIT), .LANES(4)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .len_i   (len_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .cfg_q_o (cfg_q),
    .cfg_d_o (cfg_d)
  );

  cfg_read_port u_rd (
    .cfg_i   (cfg_q),
    .addr_i  (addr_i),
    .len_i   (len_i),
    .rdata_o (rdata_o)
  );

  cfg_remap_det u_remap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_q_i (cfg_q),
    .cfg_d_i (cfg_d),
    .remap_o (remap_o)
  );
endmodule

// File: rtl/cfg_space_checker.sv
module cfg_space_checker
  import cfg_space_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  addr_i,
  input logic [2:0]  len_i,
  input logic        wr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        remap_o,
  input cfg_img_t    cfg_q
);
  assert_id_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_q[3:0]) && $stable(cfg_q[14]));

  assert_cmd_reserved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[CMD_OFF][7:3] == 5'b0 && cfg_q[CMD_OFF+1] == 8'h00);

  assert_dev_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && len_i == 3'd1 && addr_i == 8'h40) |=> cfg_q[DEV_SPEC_OFF] == $past(wdata_i[7:0]));

  assert_dword_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i == 3'd4 && addr_i > 8'hFC) |-> rdata_o == 32'hFFFF_FFFF);

  assert_remap_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |-> $past(wr_i));

  assert_hold_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_q));
endmodule

bind masked_cfg_space cfg_space_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .len_i   (len_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .remap_o (remap_o),
  .cfg_q   (cfg_q)
);

// File: tb/sim_masked_cfg_space.sv
module sim_masked_cfg_space;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [2:0]  len_i = 3'd1;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        remap_o;

  int checks = 0;
  int errors = 0;
  int mdl[256];

  always #2 clk = ~clk;

  masked_cfg_space u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .len_i(len_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .remap_o(remap_o)
  );

  // Default parameters: region0 mem 4 KiB, region1 I/O 32 B, region2 size 0x300, ROM 64 KiB
  function automatic int exp_mask(int a);
    if (a >= 'h40) return 'hFF;
    case (a)
      'h04: return 'h07;
      'h0C, 'h3C: return 'hFF;
      'h10: return 'h00;
      'h11: return 'hF0;
      'h12, 'h13: return 'hFF;
      'h14: return 'hE0;
      'h15, 'h16, 'h17: return 'hFF;
      'h30: return 'h01;
      'h31: return 'h00;
      'h32, 'h33: return 'hFF;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_init(int a);
    case (a)
      'h00: return 'hDE;
      'h01: return 'hC0;
      'h02: return 'h42;
      'h08: return 'h03;
      'h0B: return 'h02;
      'h14: return 'h01;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mdl_read(int a, int len);
    case (len)
      1: return 32'(mdl[a]);
      2: return (a <= 'hFE) ? 32'(mdl[a] | (mdl[a+1] << 8)) : 32'hFFFF_FFFF;
      4: return (a <= 'hFC) ? 32'(mdl[a] | (mdl[a+1] << 8) | (mdl[a+2] << 16) | (mdl[a+3] << 24))
                            : 32'hFFFF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Caller is at a falling edge; returns at the next falling edge.
  task automatic op(bit w, int a, int len, logic [31:0] d, string tag);
    int n;
    bit exp_remap;
    addr_i = 8'(a); len_i = 3'(len); wr_i = w; wdata_i = d;
    #1;
    check(tag, rdata_o, mdl_read(a, len), $sformatf("read @%02h len %0d", a, len));
    exp_remap = 0;
    n = (len == 1 || len == 2 || len == 4) ? len : 0;
    if (w) begin
      for (int k = 0; k < n; k++) begin
        int t, m, nv;
        t = a + k;
        if (t > 255) break;
        m = exp_mask(t);
        nv = (mdl[t] & ~m & 'hFF) | ((d >> (8*k)) & m & 'hFF);
        if (t >= 'h10 && t <= 'h27 && nv != mdl[t]) exp_remap = 1;
        if (t == 'h04 && ((nv ^ mdl[t]) & 3) != 0) exp_remap = 1;
        mdl[t] = nv;
      end
    end
    @(negedge clk);
    wr_i = 1'b0;
    check(tag, 32'(remap_o), 32'(exp_remap), "remap pulse");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = exp_init(i);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset image
    for (int i = 0; i < 256; i++) op(0, i, 1, 0, "R1");
    op(0, 'h00, 4, 0, "R1");
    op(0, 'h14, 4, 0, "R1");
    // R2 identity bytes
    op(1, 'h00, 4, 32'hFFFF_FFFF, "R2");
    op(1, 'h08, 4, 32'hFFFF_FFFF, "R2");
    op(1, 'h0C, 4, 32'hFFFF_FFFF, "R2");
    op(0, 'h00, 4, 0, "R2");
    op(0, 'h0C, 4, 0, "R2");
    // R3 writable bytes
    op(1, 'h0C, 1, 32'h5A, "R3");
    op(1, 'h3C, 1, 32'hA5, "R3");
    op(1, 'h40, 4, 32'h1234_5678, "R3");
    op(1, 'hFF, 1, 32'h77, "R3");
    op(0, 'h40, 4, 0, "R3");
    op(0, 'h3C, 1, 0, "R3");
    // R4 command register
    op(1, 'h04, 2, 32'hFFFF, "R4");
    op(0, 'h04, 2, 0, "R4");
    // R5 region masks
    op(1, 'h10, 4, 32'hFFFF_FFFF, "R5");
    op(0, 'h10, 4, 0, "R5");
    op(1, 'h14, 4, 32'h0000_0000, "R10");
    op(1, 'h14, 4, 32'h1234_5678, "R5");
    op(0, 'h14, 4, 0, "R5");
    op(1, 'h30, 4, 32'hFFFF_FFFF, "R10");
    op(0, 'h30, 4, 0, "R5");
    // R6 absent regions
    op(1, 'h18, 4, 32'hFFFF_FFFF, "R6");
    op(1, 'h1C, 4, 32'hFFFF_FFFF, "R6");
    op(0, 'h18, 4, 0, "R6");
    op(0, 'h24, 4, 0, "R6");
    // R7 little-endian, drop at end
    op(1, 'hFE, 4, 32'hAABB_CCDD, "R7");
    op(0, 'hFE, 1, 0, "R7");
    op(0, 'hFF, 1, 0, "R7");
    op(0, 'h00, 1, 0, "R7");
    op(1, 'hFF, 2, 32'h1122, "R7");
    op(0, 'h00, 1, 0, "R7");
    op(1, 'h50, 2, 32'hBEEF, "R7");
    op(0, 'h50, 4, 0, "R7");
    // R8 read range and length codes
    op(0, 'hFE, 2, 0, "R8");
    op(0, 'hFF, 2, 0, "R8");
    op(0, 'hFC, 4, 0, "R8");
    op(0, 'hFD, 4, 0, "R8");
    op(0, 'h40, 3, 0, "R8");
    op(1, 'h40, 3, 32'hFFFF_FFFF, "R8");
    op(0, 'h40, 4, 0, "R8");
    // R9/R10 remap on decode bits only
    op(1, 'h04, 1, 32'h07, "R10");
    op(1, 'h04, 1, 32'h03, "R10");
    op(1, 'h04, 1, 32'h01, "R9");
    op(1, 'h04, 1, 32'h00, "R9");
    op(1, 'h13, 1, 32'h80, "R9");
    op(1, 'h13, 1, 32'h80, "R10");
    // R11 pattern sweep, mixed lengths
    for (int i = 0; i < 256; i++) op(1, i, (i % 3 == 0) ? 4 : ((i % 3 == 1) ? 2 : 1),
                                     32'(i * 32'h0101_0101 + 32'h3719_5A2D), "R11");
    for (int i = 0; i < 256; i++) op(0, i, 1, 0, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R11 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule